// File: doc/BRIEF.md
# Cache line reservation tracker

This block keeps the per-line bookkeeping for one cache line in a multiprocessor memory model. It holds an eight-bit status word that records whether the line is valid, writable, dirty, referenced, or brought in by a hardware prefetch and not yet touched. It also holds a small table of load-linked reservations, each tagged with a processor number and a thread number. The data array, tag lookup, replacement and coherence protocol are outside this block.

One operation is presented per clock on `op_kind` with `op_valid`. Load-linked requests add a reservation. Store-conditional requests succeed only when their own processor/thread pair holds a reservation. Any store clears the table, and so does an invalidate. Stores and store-conditionals answer one cycle later with a write-proceed flag and a success flag. The status predicates are decoded from the status word without delay.

Top module: `line_resv_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the status word becomes 0, every reservation is dropped and `resp_valid`, `resp_write_go` and `resp_sc_pass` become 0.
- R2: Status word bit positions: valid = bit 0, writable = bit 1, dirty = bit 2, referenced = bit 4, prefetched-untouched = bit 5. Bits 3, 6 and 7 always read 0. A fill loads `fill_status` masked with 0x37.
- R3: `stat_writable` is 1 only when bits 0 and 1 are both set. `stat_valid`, `stat_dirty`, `stat_referenced` and `stat_prefetched` each reflect their single bit in the same cycle.
- R4: With `op_valid` high, `op_kind` selects 0 no-op, 1 load-linked, 2 plain store, 3 store-conditional, 4 invalidate, 5 fill, 6 touch, 7 no-op. With `op_valid` low, nothing changes.
- R5: A load-linked records the pair (`req_cpu`, `req_thr`). If that pair is already held, no new entry is made.
- R6: A store-conditional passes when a held reservation matches both `req_cpu` and `req_thr`. On the next edge it gives `resp_valid`=1 and `resp_sc_pass`=1 on success, 0 on failure.
- R7: Every store-conditional, whether it passes or fails, drops all reservations.
- R8: A plain store answers `resp_valid`=1, `resp_write_go`=1 and `resp_sc_pass`=0, and drops all reservations.
- R9: `resp_write_go` is 0 after a responded operation only for a failed store-conditional. After non-store operations all three response outputs are 0.
- R10: An invalidate sets the status word to 0 and drops all reservations.
- R11: When all `DEPTH` entries are held, a load-linked of a new pair replaces the oldest entry, so a later store-conditional from the replaced pair fails.
- R12: A touch sets bit 4 and clears bit 5. A write that proceeds (a store, or a passing store-conditional) sets bit 2 if bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation code (see R4) |
| req_cpu | input | CPU_W | Requesting processor number |
| req_thr | input | THR_W | Requesting thread number |
| fill_status | input | 8 | Status word applied by a fill |
| resp_valid | output | 1 | A store or store-conditional was answered |
| resp_write_go | output | 1 | The answered write may proceed |
| resp_sc_pass | output | 1 | Store-conditional result, 1 = success |
| status_word | output | 8 | Current status word |
| stat_valid | output | 1 | Line valid |
| stat_writable | output | 1 | Line valid and writable |
| stat_dirty | output | 1 | Line modified |
| stat_referenced | output | 1 | Line referenced |
| stat_prefetched | output | 1 | Line prefetched, not yet touched |

## Verification
The bench builds the block with `DEPTH`=4 and two-bit processor and thread numbers. With these values the table fills after four distinct pairs, so replacement of the oldest entry can be reached in a few operations. A duplicate load-linked then decides whether a fifth pair evicts a live context or only a stale one. The small identifier widths also let pairs that differ only in processor or only in thread sit side by side, which shows that matching needs both fields.

// File: rtl/line_resv_pkg.sv
// Shared operation codes and status word layout for the reservation tracker.
// Assumes one operation per cycle; bit positions are fixed by the status encoding.
package line_resv_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LL    = 3'd1,
        OP_ST    = 3'd2,
        OP_SC    = 3'd3,
        OP_INV   = 3'd4,
        OP_FILL  = 3'd5,
        OP_TOUCH = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    localparam int STAT_W   = 8;
    localparam int BIT_VAL  = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_DRT  = 2;
    localparam int BIT_REF  = 4;
    localparam int BIT_PF   = 5;
    localparam logic [STAT_W-1:0] STAT_MASK =
        (STAT_W'(1) << BIT_VAL) | (STAT_W'(1) << BIT_WR) | (STAT_W'(1) << BIT_DRT) |
        (STAT_W'(1) << BIT_REF) | (STAT_W'(1) << BIT_PF);

endpackage

// File: rtl/resv_table.sv
// Reservation table: holds up to DEPTH (cpu, thread) pairs.
// Inserts at a rotating pointer so the oldest entry is replaced when full;
// a pair already present is not inserted again. Clear empties everything.
// Assumes insert and clear are never requested in the same cycle.
module resv_table #(
    parameter int DEPTH = 8,
    parameter int CPU_W = 4,
    parameter int THR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic             clr_en,
    input  logic [CPU_W-1:0] cpu,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] ent_v;
    logic [CPU_W-1:0] ent_cpu [DEPTH];
    logic [THR_W-1:0] ent_thr [DEPTH];
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] wr_ptr;

    // Compare the request against every held entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = ent_v[i] && (ent_cpu[i] == cpu) && (ent_thr[i] == thr);
    end
    assign hit = |match;

    // Advance the insertion pointer, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_en) begin
            wr_ptr <= '0;
        end else if (ins_en && !hit) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
        end
    end

    // Hold each entry; write the slot under the pointer on a new pair.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n || clr_en) begin
                ent_v[i]   <= 1'b0;
                ent_cpu[i] <= '0;
                ent_thr[i] <= '0;
            end else if (ins_en && !hit && (wr_ptr == PTR_W'(i))) begin
                ent_v[i]   <= 1'b1;
                ent_cpu[i] <= cpu;
                ent_thr[i] <= thr;
            end
        end
    end

endmodule

// File: rtl/line_status_reg.sv
// Status word register for one line.
// Invalidate zeroes it, fill loads a masked word, touch marks it referenced
// and no longer prefetched, a proceeding write marks a valid line dirty.
// Assumes at most one of the controls is active per cycle.
module line_status_reg
    import line_resv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_inval,
    input  logic              do_fill,
    input  logic [STAT_W-1:0] fill_word,
    input  logic              do_touch,
    input  logic              do_write,
    output logic [STAT_W-1:0] word
);
    // Update the status word according to the operation of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || do_inval) begin
            word <= '0;
        end else if (do_fill) begin
            word <= fill_word & STAT_MASK;
        end else if (do_touch) begin
            word[BIT_REF] <= 1'b1;
            word[BIT_PF]  <= 1'b0;
        end else if (do_write && word[BIT_VAL]) begin
            word[BIT_DRT] <= 1'b1;
        end
    end

endmodule

// File: rtl/status_decode.sv
// Decodes the status word into the five line predicates.
// Writable requires valid as well; the rest test one bit each.
module status_decode
    import line_resv_pkg::*;
(
    input  logic [STAT_W-1:0] word,
    output logic              is_valid,
    output logic              is_writable,
    output logic              is_dirty,
    output logic              is_referenced,
    output logic              is_prefetched
);
    // Combinational predicate decode.
    always_comb begin
        is_valid      = word[BIT_VAL];
        is_writable   = word[BIT_VAL] & word[BIT_WR];
        is_dirty      = word[BIT_DRT];
        is_referenced = word[BIT_REF];
        is_prefetched = word[BIT_PF];
    end

endmodule

// File: rtl/line_resv_tracker.sv
// Top of the per-line reservation tracker.
// Decodes one operation per cycle, steers it to the reservation table and
// status register, and registers the store / store-conditional answer.
// Assumes requests are sampled on the rising edge; reset is synchronous.
module line_resv_tracker
    import line_resv_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CPU_W = 4,
    parameter int THR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [THR_W-1:0] req_thr,
    input  logic [7:0]       fill_status,
    output logic             resp_valid,
    output logic             resp_write_go,
    output logic             resp_sc_pass,
    output logic [7:0]       status_word,
    output logic             stat_valid,
    output logic             stat_writable,
    output logic             stat_dirty,
    output logic             stat_referenced,
    output logic             stat_prefetched
);
    op_e  kind;
    logic is_ll, is_st, is_sc, is_inv, is_fill, is_touch;
    logic hit;

    // Qualify the operation code with op_valid.
    always_comb begin
        kind     = op_e'(op_kind);
        is_ll    = op_valid && (kind == OP_LL);
        is_st    = op_valid && (kind == OP_ST);
        is_sc    = op_valid && (kind == OP_SC);
        is_inv   = op_valid && (kind == OP_INV);
        is_fill  = op_valid && (kind == OP_FILL);
        is_touch = op_valid && (kind == OP_TOUCH);
    end

    resv_table #(
        .DEPTH (DEPTH),
        .CPU_W (CPU_W),
        .THR_W (THR_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .ins_en (is_ll),
        .clr_en (is_st | is_sc | is_inv),
        .cpu    (req_cpu),
        .thr    (req_thr),
        .hit    (hit)
    );

    line_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_inval  (is_inv),
        .do_fill   (is_fill),
        .fill_word (fill_status),
        .do_touch  (is_touch),
        .do_write  (is_st | (is_sc & hit)),
        .word      (status_word)
    );

    status_decode u_decode (
        .word          (status_word),
        .is_valid      (stat_valid),
        .is_writable   (stat_writable),
        .is_dirty      (stat_dirty),
        .is_referenced (stat_referenced),
        .is_prefetched (stat_prefetched)
    );

    // Register the answer to stores and store-conditionals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_write_go <= 1'b0;
            resp_sc_pass  <= 1'b0;
        end else begin
            resp_valid    <= is_st | is_sc;
            resp_write_go <= is_st | (is_sc & hit);
            resp_sc_pass  <= is_sc & hit;
        end
    end

endmodule

// File: rtl/line_resv_tracker_chk.sv
// Property checker for the reservation tracker, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module line_resv_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_kind,
    input logic       resp_valid,
    input logic       resp_write_go,
    input logic       resp_sc_pass,
    input logic [7:0] status_word,
    input logic       stat_valid,
    input logic       stat_writable
);
    a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[3] == 1'b0) && (status_word[7:6] == 2'b00));

    a_r3_writable_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        stat_writable |-> stat_valid);

    a_r6_pass_only_after_sc: assert property (@(posedge clk) disable iff (!rst_n)
        resp_sc_pass |-> ($past(rst_n) && $past(op_valid) && ($past(op_kind) == 3'd3)));

    a_r9_block_only_failed_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_write_go) |-> (!resp_sc_pass && ($past(op_kind) == 3'd3)));

    a_r10_inval_zeroes_status: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_kind) == 3'd4)) |-> (status_word == 8'h00));

    a_r9_quiet_without_store: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> !resp_valid && !resp_write_go && !resp_sc_pass);

endmodule

bind line_resv_tracker line_resv_tracker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .resp_valid    (resp_valid),
    .resp_write_go (resp_write_go),
    .resp_sc_pass  (resp_sc_pass),
    .status_word   (status_word),
    .stat_valid    (stat_valid),
    .stat_writable (stat_writable)
);

// File: tb/line_resv_tracker_tb.sv
`timescale 1ns/1ps
module line_resv_tracker_tb;
    localparam int DEPTH = 4;
    localparam int CPU_W = 2;
    localparam int THR_W = 2;
    localparam int NV    = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_kind = '0;
    logic [CPU_W-1:0] req_cpu = '0;
    logic [THR_W-1:0] req_thr = '0;
    logic [7:0] fill_status = '0;
    logic resp_valid, resp_write_go, resp_sc_pass;
    logic [7:0] status_word;
    logic stat_valid, stat_writable, stat_dirty, stat_referenced, stat_prefetched;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    line_resv_tracker #(.DEPTH(DEPTH), .CPU_W(CPU_W), .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .req_cpu(req_cpu), .req_thr(req_thr), .fill_status(fill_status),
        .resp_valid(resp_valid), .resp_write_go(resp_write_go), .resp_sc_pass(resp_sc_pass),
        .status_word(status_word), .stat_valid(stat_valid), .stat_writable(stat_writable),
        .stat_dirty(stat_dirty), .stat_referenced(stat_referenced),
        .stat_prefetched(stat_prefetched)
    );

    // Vector: kind(3) cpu(2) thr(2) fill(8) exp_rv exp_wgo exp_pass exp_stat(8)
    localparam logic [25:0] VEC [NV] = '{
        {3'd5,2'd0,2'd0,8'h23, 3'b000, 8'h23},  // 0  fill V,W,P (R2)
        {3'd6,2'd0,2'd0,8'h00, 3'b000, 8'h13},  // 1  touch (R12)
        {3'd1,2'd1,2'd0,8'h00, 3'b000, 8'h13},  // 2  LL 1/0
        {3'd3,2'd1,2'd1,8'h00, 3'b100, 8'h13},  // 3  SC 1/1 wrong thread fails (R6, R9)
        {3'd3,2'd1,2'd0,8'h00, 3'b100, 8'h13},  // 4  SC 1/0 fails: table cleared by SC (R7)
        {3'd1,2'd1,2'd0,8'h00, 3'b000, 8'h13},  // 5  LL 1/0
        {3'd1,2'd1,2'd0,8'h00, 3'b000, 8'h13},  // 6  LL 1/0 again
        {3'd3,2'd1,2'd0,8'h00, 3'b111, 8'h17},  // 7  SC passes, dirty set (R6, R12)
        {3'd1,2'd2,2'd3,8'h00, 3'b000, 8'h17},  // 8  LL 2/3
        {3'd2,2'd0,2'd0,8'h00, 3'b110, 8'h17},  // 9  plain store (R8)
        {3'd3,2'd2,2'd3,8'h00, 3'b100, 8'h17},  // 10 SC fails after store (R8)
        {3'd1,2'd0,2'd1,8'h00, 3'b000, 8'h17},  // 11 LL 0/1
        {3'd1,2'd3,2'd2,8'h00, 3'b000, 8'h17},  // 12 LL 3/2
        {3'd3,2'd3,2'd2,8'h00, 3'b111, 8'h17},  // 13 SC 3/2 passes
        {3'd1,2'd0,2'd0,8'h00, 3'b000, 8'h17},  // 14 fill table
        {3'd1,2'd0,2'd1,8'h00, 3'b000, 8'h17},  // 15
        {3'd1,2'd0,2'd2,8'h00, 3'b000, 8'h17},  // 16
        {3'd1,2'd0,2'd3,8'h00, 3'b000, 8'h17},  // 17 table full
        {3'd1,2'd1,2'd0,8'h00, 3'b000, 8'h17},  // 18 replaces oldest 0/0 (R11)
        {3'd3,2'd0,2'd0,8'h00, 3'b100, 8'h17},  // 19 SC 0/0 fails (R11)
        {3'd1,2'd0,2'd0,8'h00, 3'b000, 8'h17},  // 20
        {3'd1,2'd0,2'd1,8'h00, 3'b000, 8'h17},  // 21
        {3'd1,2'd0,2'd2,8'h00, 3'b000, 8'h17},  // 22
        {3'd1,2'd0,2'd0,8'h00, 3'b000, 8'h17},  // 23 duplicate, no entry (R5)
        {3'd1,2'd0,2'd3,8'h00, 3'b000, 8'h17},  // 24 table full
        {3'd1,2'd1,2'd1,8'h00, 3'b000, 8'h17},  // 25 replaces 0/0
        {3'd3,2'd0,2'd1,8'h00, 3'b111, 8'h17},  // 26 SC 0/1 still held (R5, R11)
        {3'd1,2'd2,2'd2,8'h00, 3'b000, 8'h17},  // 27 LL 2/2
        {3'd4,2'd0,2'd0,8'h00, 3'b000, 8'h00},  // 28 invalidate (R10)
        {3'd3,2'd2,2'd2,8'h00, 3'b100, 8'h00},  // 29 SC fails after invalidate (R10)
        {3'd2,2'd1,2'd1,8'h00, 3'b110, 8'h00},  // 30 store to invalid line, no dirty (R12)
        {3'd5,2'd0,2'd0,8'h0F, 3'b000, 8'h07},  // 31 fill masks bit 3 (R2)
        {3'd5,2'd0,2'd0,8'h02, 3'b000, 8'h02},  // 32 writable without valid (R3)
        {3'd5,2'd0,2'd0,8'hFF, 3'b000, 8'h37},  // 33 all bits (R2)
        {3'd0,2'd0,2'd0,8'h00, 3'b000, 8'h37},  // 34 no-op (R4)
        {3'd7,2'd0,2'd0,8'h00, 3'b000, 8'h37}   // 35 reserved code is no-op (R4)
    };

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Predicates derived from the expected word per R3.
    task automatic check_stat(input string req, input logic [7:0] exp);
        logic [4:0] ep, ap;
        check(req, "status_word", {24'd0, status_word}, {24'd0, exp});
        ep = {exp[0], exp[0] & exp[1], exp[2], exp[4], exp[5]};
        ap = {stat_valid, stat_writable, stat_dirty, stat_referenced, stat_prefetched};
        check("R3", "predicates", {27'd0, ap}, {27'd0, ep});
    endtask

    task automatic run_op(input logic v, input logic [2:0] k, input logic [1:0] c,
                          input logic [1:0] t, input logic [7:0] f);
        @(negedge clk);
        op_valid = v; op_kind = k; req_cpu = c; req_thr = t; fill_status = f;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd1: return "R5";
            3'd2: return "R8";
            3'd3: return "R6";
            3'd4: return "R10";
            3'd5: return "R2";
            3'd6: return "R12";
            default: return "R4";
        endcase
    endfunction

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "resp", {29'd0, resp_valid, resp_write_go, resp_sc_pass}, 32'd0);
        check_stat("R1", 8'h00);
        rst_n = 1'b1;

        // R1: empty table after reset, SC with no load-linked fails
        run_op(1'b1, 3'd3, 2'd0, 2'd0, 8'h00);
        check("R1", "sc after reset", {29'd0, resp_valid, resp_write_go, resp_sc_pass}, 32'd4);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            run_op(1'b1, v[25:23], v[22:21], v[20:19], v[18:11]);
            check(tag_of(v[25:23]), $sformatf("vec %0d resp", i),
                  {29'd0, resp_valid, resp_write_go, resp_sc_pass}, {29'd0, v[10:8]});
            check_stat(tag_of(v[25:23]), v[7:0]);
        end

        // R4: op_valid low ignores an invalidate code
        run_op(1'b0, 3'd4, 2'd0, 2'd0, 8'h00);
        check_stat("R4", 8'h37);

        // R4: op_valid low ignores a load-linked; SC 1/2 then fails
        run_op(1'b0, 3'd1, 2'd1, 2'd2, 8'h00);
        run_op(1'b1, 3'd3, 2'd1, 2'd2, 8'h00);
        check("R4", "ignored LL", {29'd0, resp_valid, resp_write_go, resp_sc_pass}, 32'd4);

        // R1: mid-run reset drops reservations and status
        run_op(1'b1, 3'd1, 2'd1, 2'd1, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_stat("R1", 8'h00);
        run_op(1'b1, 3'd3, 2'd1, 2'd1, 8'h00);
        check("R1", "sc after mid reset", {29'd0, resp_valid, resp_write_go, resp_sc_pass}, 32'd4);

        // R9: response flags return to 0 after a non-store op
        run_op(1'b1, 3'd6, 2'd0, 2'd0, 8'h00);
        check("R9", "quiet after touch", {29'd0, resp_valid, resp_write_go, resp_sc_pass}, 32'd0);

        finish_run();
    end
endmodule